// File: doc/BRIEF.md
# Saturating Wiper Position Counter with Tap Select

This block holds the volatile position of a digitally set resistor tap and turns it into a one-hot select over the tap switches of a resistor string. A command layer changes the position in four ways: it restores the stored default setting on a power-on recall strobe, it writes a value directly, it copies one of four stored setting registers, or it moves the position up or down one step. The stored settings come in on a flat bus and are not kept here.

Each change takes effect at the next clock edge, and the registered position and the registered tap select always agree. Stepping saturates at both ends of the string and never wraps. When several requests arrive in the same cycle, a fixed priority picks one of them.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wiper_pos` becomes 0 and `tap_sel` becomes 64'h1, which selects the low end terminal.
- R2: `tap_sel` always has exactly one bit set, and that bit is bit number `wiper_pos`. Position 0 drives bit 0 (low end terminal) and position 63 drives bit 63 (high end terminal). `tap_sel` changes at the same edge as `wiper_pos`.
- R3: A cycle with `recall` high loads the stored default (entry 0 of `set_bank`, bits [5:0]) into the position at the next edge. This overrides every other request.
- R4: A cycle with `wr_en` high and `recall` low loads `wr_val` at the next edge.
- R5: A cycle with `xfer_en` high and both `recall` and `wr_en` low loads entry `xfer_sel` of `set_bank` at the next edge. Entry i occupies bits [6i+5:6i].
- R6: With no load request, `step_up` alone adds one to the position and `step_dn` alone subtracts one. When both are high, the position does not change.
- R7: A step up at position 63 leaves it at 63, and a step down at position 0 leaves it at 0.
- R8: Any load request (`recall`, `wr_en` or `xfer_en`) wins over a step request in the same cycle, and that step has no effect.
- R9: With no request in a cycle, the position and the select hold their values. Every request takes effect within one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recall | input | 1 | Power-on recall strobe: load stored entry 0 |
| wr_en | input | 1 | Direct write strobe |
| wr_val | input | 6 | Direct write value |
| xfer_en | input | 1 | Transfer strobe: load a stored entry |
| xfer_sel | input | 2 | Index of the stored entry to transfer |
| set_bank | input | 24 | Four stored 6-bit settings, entry i at [6i+5:6i] |
| step_up | input | 1 | Step one segment toward the high terminal |
| step_dn | input | 1 | Step one segment toward the low terminal |
| wiper_pos | output | 6 | Registered wiper position |
| tap_sel | output | 64 | Registered one-hot tap switch select |

## Verification
Two functions can meet in one cycle: a load (recall, write or transfer) and a step. Two loads of different kinds can also meet. The random phase raises steps often and loads more rarely, so the two kinds often land in the same cycle. Directed cycles also force a load together with a step at positions 0 and 63. A bench function applies the stated priority to a model position, and each result is judged by comparing the registered position and the full 64-bit select against that model one edge later.

// File: rtl/wpr_pkg.sv
// Package: shared types for the wiper position counter.
// Assumes a single source is selected per cycle by the arbiter.
package wpr_pkg;
    // Source that sets the next wiper position.
    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_RECALL = 3'd1,
        SRC_WRITE  = 3'd2,
        SRC_XFER   = 3'd3,
        SRC_STEP   = 3'd4
    } wpr_src_e;
endpackage

// File: rtl/wpr_src_arb.sv
// Module: priority arbiter for the wiper position sources.
// Priority, highest first: recall, direct write, transfer, step.
// Assumes set_bank holds NREG entries of W bits, entry 0 first.
module wpr_src_arb
    import wpr_pkg::*;
#(
    parameter int W    = 6,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                recall,
    input  logic                wr_en,
    input  logic [W-1:0]        wr_val,
    input  logic                xfer_en,
    input  logic [SELW-1:0]     xfer_sel,
    input  logic [NREG*W-1:0]   set_bank,
    input  logic                step_req,
    output wpr_src_e            src,
    output logic [W-1:0]        load_val
);
    // Pick the winning source by fixed priority.
    always_comb begin
        if (recall)        src = SRC_RECALL;
        else if (wr_en)    src = SRC_WRITE;
        else if (xfer_en)  src = SRC_XFER;
        else if (step_req) src = SRC_STEP;
        else               src = SRC_HOLD;
    end

    // Route the parallel load value for the winning source.
    always_comb begin
        case (src)
            SRC_RECALL: load_val = set_bank[W-1:0];
            SRC_WRITE:  load_val = wr_val;
            SRC_XFER:   load_val = set_bank[xfer_sel*W +: W];
            default:    load_val = '0;
        endcase
    end

    // R8: a load request must never lose to a step request.
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (recall || wr_en || xfer_en) |-> (src != SRC_STEP && src != SRC_HOLD));
    // R3: recall overrides the other loads.
    p_recall_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recall |-> (load_val == set_bank[W-1:0]));
endmodule

// File: rtl/wpr_step_sat.sv
// Module: saturating one-step increment/decrement.
// Assumes up and dn are both sampled in the same cycle; both high means no move.
module wpr_step_sat #(
    parameter int W = 6
) (
    input  logic [W-1:0] pos,
    input  logic         up,
    input  logic         dn,
    output logic [W-1:0] stepped
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Move one segment unless already at the matching end.
    always_comb begin
        stepped = pos;
        if (up && !dn && pos != TOP)
            stepped = pos + W'(1);
        else if (dn && !up && pos != '0)
            stepped = pos - W'(1);
    end
endmodule

// File: rtl/wpr_tap_decode.sv
// Module: registered one-hot decode of the next wiper position.
// Assumes next_pos is the value the position register loads at the same edge.
module wpr_tap_decode #(
    parameter int W = 6,
    localparam int NTAP = 1 << W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    next_pos,
    output logic [NTAP-1:0] tap_q
);
    logic [NTAP-1:0] tap_d;

    // One comparator per tap switch.
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        assign tap_d[i] = (next_pos == W'(i));
    end

    // Register the select; reset selects the low end tap.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= NTAP'(1);
        else        tap_q <= tap_d;
    end

    // R2: exactly one switch on at any time.
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tap_q));
endmodule

// File: rtl/wiper_pos_ctrl.sv
// Module: wiper position register with load, saturating step and tap select.
// Assumes strobes are single-cycle requests from a command layer.
module wiper_pos_ctrl
    import wpr_pkg::*;
#(
    parameter int W    = 6,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG),
    localparam int NTAP = 1 << W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recall,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_val,
    input  logic              xfer_en,
    input  logic [SELW-1:0]   xfer_sel,
    input  logic [NREG*W-1:0] set_bank,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [W-1:0]      wiper_pos,
    output logic [NTAP-1:0]   tap_sel
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    wpr_src_e     src;
    logic [W-1:0] load_val;
    logic [W-1:0] stepped;
    logic [W-1:0] pos_d;

    wpr_src_arb #(.W(W), .NREG(NREG)) i_arb (
        .clk(clk), .rst_n(rst_n),
        .recall(recall), .wr_en(wr_en), .wr_val(wr_val),
        .xfer_en(xfer_en), .xfer_sel(xfer_sel), .set_bank(set_bank),
        .step_req(step_up || step_dn),
        .src(src), .load_val(load_val)
    );

    wpr_step_sat #(.W(W)) i_step (
        .pos(wiper_pos), .up(step_up), .dn(step_dn), .stepped(stepped)
    );

    // Choose the next position from the winning source.
    always_comb begin
        case (src)
            SRC_HOLD: pos_d = wiper_pos;
            SRC_STEP: pos_d = stepped;
            default:  pos_d = load_val;
        endcase
    end

    // Position register; reset to the low end.
    always_ff @(posedge clk) begin
        if (!rst_n) wiper_pos <= '0;
        else        wiper_pos <= pos_d;
    end

    wpr_tap_decode #(.W(W)) i_dec (
        .clk(clk), .rst_n(rst_n), .next_pos(pos_d), .tap_q(tap_sel)
    );

    // R2: the set select bit matches the position.
    p_tap_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_sel[wiper_pos]);
    // R3: recall loads entry 0 at the next edge.
    p_recall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recall |=> wiper_pos == $past(set_bank[W-1:0]));
    // R4: direct write without recall loads the value.
    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !recall) |=> wiper_pos == $past(wr_val));
    // R7: no wrap at the high end.
    p_no_wrap_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !recall && !wr_en && !xfer_en && wiper_pos == TOP) |=> wiper_pos == TOP);
    // R7: no wrap at the low end.
    p_no_wrap_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !recall && !wr_en && !xfer_en && wiper_pos == '0) |=> wiper_pos == '0);
    // R9: no request keeps the position.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !wr_en && !xfer_en && !step_up && !step_dn) |=> $stable(wiper_pos));
endmodule

// File: tb/test_wiper_pos_ctrl.sv
// Bench: fixed-seed random requests plus directed corners, checked against a model.
module test_wiper_pos_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recall = 1'b0, wr_en = 1'b0, xfer_en = 1'b0;
    logic        step_up = 1'b0, step_dn = 1'b0;
    logic [5:0]  wr_val = '0;
    logic [1:0]  xfer_sel = '0;
    logic [23:0] set_bank = '0;
    logic [5:0]  wiper_pos;
    logic [63:0] tap_sel;

    int n_chk = 0;
    int n_fail = 0;
    logic [5:0] model = '0;

    always #10 clk = ~clk;

    wiper_pos_ctrl i_wiper_pos_ctrl (
        .clk(clk), .rst_n(rst_n), .recall(recall), .wr_en(wr_en), .wr_val(wr_val),
        .xfer_en(xfer_en), .xfer_sel(xfer_sel), .set_bank(set_bank),
        .step_up(step_up), .step_dn(step_dn), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    // Expected next position from the requirements (R3..R9).
    function automatic logic [5:0] next_model(logic [5:0] p);
        if (recall)  return set_bank[5:0];
        if (wr_en)   return wr_val;
        if (xfer_en) return set_bank[xfer_sel*6 +: 6];
        if (step_up && !step_dn) return (p == 6'd63) ? p : p + 6'd1;
        if (step_dn && !step_up) return (p == 6'd0) ? p : p - 6'd1;
        return p;
    endfunction

    task automatic check(string req);
        logic [63:0] exp_tap;
        exp_tap = 64'd1 << model;
        n_chk++;
        if (wiper_pos !== model || tap_sel !== exp_tap) begin
            n_fail++;
            $display("FAIL %s pos=%0d tap=%h expected pos=%0d tap=%h",
                     req, wiper_pos, tap_sel, model, exp_tap);
        end
    endtask

    // Apply the current inputs for one edge, then compare after it.
    task automatic cycle(string req);
        model = next_model(model);
        @(posedge clk);
        @(negedge clk);
        check(req);
        recall = 0; wr_en = 0; xfer_en = 0; step_up = 0; step_dn = 0;
    endtask

    initial begin
        #3000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        set_bank = {6'd40, 6'd9, 6'd63, 6'd21};
        repeat (3) @(negedge clk);
        model = '0;
        check("R1 reset");
        rst_n = 1'b1;
        // R3: recall entry 0.
        recall = 1; cycle("R3 recall");
        // R9: hold.
        cycle("R9 hold");
        // R4: direct write.
        wr_en = 1; wr_val = 6'd62; cycle("R4 write");
        // R2/R7: high end reached then saturate.
        step_up = 1; cycle("R2 step to 63");
        step_up = 1; cycle("R7 no wrap high");
        // R6: both steps cancel.
        step_up = 1; step_dn = 1; cycle("R6 both steps");
        // R5: transfer entry 2 (value 9), then entry 1 (63).
        xfer_en = 1; xfer_sel = 2'd2; cycle("R5 xfer 2");
        xfer_en = 1; xfer_sel = 2'd1; cycle("R5 xfer 1");
        // R8: write wins over step down.
        wr_en = 1; wr_val = 6'd0; step_dn = 1; cycle("R8 write beats step");
        step_dn = 1; cycle("R7 no wrap low");
        step_up = 1; cycle("R6 step up");
        step_dn = 1; cycle("R6 step down");
        // R8/R3: recall beats write and transfer and step.
        recall = 1; wr_en = 1; wr_val = 6'd5; xfer_en = 1; xfer_sel = 2'd3; step_up = 1;
        cycle("R8 recall first");
        // R8: write beats transfer.
        wr_en = 1; wr_val = 6'd33; xfer_en = 1; xfer_sel = 2'd3; cycle("R8 write beats xfer");
        // R8: transfer beats step at the top.
        xfer_en = 1; xfer_sel = 2'd1; step_dn = 1; cycle("R8 xfer beats step");
        // Random mix.
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            set_bank = {$urandom_range(0,63) > 40 ? 6'd63 : 6'($urandom),
                        6'($urandom), 6'($urandom),
                        $urandom_range(0,3) == 0 ? 6'd0 : 6'($urandom)};
            recall  = (r < 3);
            wr_en   = ($urandom_range(0, 99) < 6);
            wr_val  = ($urandom_range(0, 3) == 0) ? 6'd63 : 6'($urandom);
            xfer_en = ($urandom_range(0, 99) < 6);
            xfer_sel = 2'($urandom);
            step_up = ($urandom_range(0, 99) < 45);
            step_dn = ($urandom_range(0, 99) < 35);
            cycle("R2 R6 R8 random");
        end
        // R1: reset again from a nonzero position.
        wr_en = 1; wr_val = 6'd17; cycle("R4 write");
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        model = '0;
        check("R1 reset again");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule